// File: doc/BRIEF.md
# Shift-Track Word Memory

This block is a synthesizable behavioural model of a tape-style memory. Each track holds a row of bits, and only one cell position, the port, can be read or written. To reach a stored bit, every cell of the track moves one place per cycle until that bit sits at the port. Several tracks move together under one shared alignment, so one word is read or written across all of them at once.

A client issues a read or a write for a logical bit address with a valid/ready handshake. The controller keeps the current alignment (the address whose bits sit at the port). It works out how far the tracks must move and in which direction, steps them one position per cycle, and then does the access in one more cycle. Spare cells on both sides of every track hold the bits that are shifted away from the port, so nothing is lost at either extreme of the alignment range.

Top module: `racetrack_mem`

## Requirements
- R1: After reset, req_ready is 1, rd_valid, shift_active and shift_left are 0, the alignment is address 0, and every stored word reads back as 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access cycle has ended.
- R3: For a request at address A with current alignment O, shift_active is 1 for exactly |A−O| consecutive cycles, starting in the cycle after acceptance. Each of those cycles moves the tracks by one position. shift_active is 0 at all other times.
- R4: While shifting, shift_left is 1 when A > O (the alignment counts up) and 0 when A < O. Every step moves toward A, so the number of steps is the minimum possible.
- R5: When A equals O, no shift happens and the access takes place in the cycle right after acceptance.
- R6: For a read, rd_valid is 1 for exactly one cycle, |A−O|+2 cycles after the accepting edge. In that cycle rd_data is the word last written to A, or 0 if A was never written.
- R7: A write stores req_wdata at address A across all tracks, and it raises no rd_valid.
- R8: Shifting never loses or alters stored data, including repeated moves between address 0 and address NUM_BITS−1.
- R9: req_ready is 1 again in the cycle after the access cycle, which is the same cycle as a read's rd_valid, so back-to-back requests are accepted without a gap.
- R10: A request presented while req_ready is 0 is ignored. A write attempted during shifting does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical bit address (below NUM_BITS) |
| req_wdata | input | WORD_W | Write word, one bit per track |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | WORD_W | Read word |
| shift_active | output | 1 | Tracks are shifting this cycle |
| shift_left | output | 1 | Shift direction: 1 = toward higher addresses |

## Verification
The hardest case to produce is a request that arrives while the tracks are still stepping. A bug there would go unnoticed unless the stray request is later shown to have had no effect. The driver keeps req_valid high with a conflicting write during long shifts. It then reads the target of that write afterwards and checks that the original word is still there. Walks between the two end addresses push the alignment to both extremes, so any data lost into the spare cells shows up as a wrong read.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_ACCESS = 2'd2
    } rt_state_e;

endpackage

// File: rtl/rt_track.sv
module rt_track #(
    parameter int NUM_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic shift_up,
    input  logic wr_en,
    input  logic wr_bit,
    output logic port_bit
);
    // Cells below and above the port hold bits moved away from it.
    localparam int LEN  = 2 * NUM_BITS - 1;
    localparam int PORT = NUM_BITS - 1;

    logic [LEN-1:0] cells_d, cells_q;

    always_comb begin
        cells_d = cells_q;
        if (shift_en) begin
            if (shift_up) cells_d = {1'b0, cells_q[LEN-1:1]};
            else          cells_d = {cells_q[LEN-2:0], 1'b0};
        end
        if (wr_en) cells_d[PORT] = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cells_q <= '0;
        else        cells_q <= cells_d;
    end

    assign port_bit = cells_q[PORT];

    AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> port_bit == $past(wr_bit)); // R7

    AST_SHIFT_UP_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_up && !wr_en) |=> port_bit == $past(cells_q[PORT+1])); // R8

    AST_SHIFT_DN_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !shift_up && !wr_en) |=> port_bit == $past(cells_q[PORT-1])); // R8

endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
    import rt_pkg::*;
#(
    parameter int NUM_BITS = 16,
    parameter int WORD_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [$clog2(NUM_BITS)-1:0] req_addr,
    input  logic [WORD_W-1:0]           req_wdata,
    input  logic [WORD_W-1:0]           port_word,
    output logic                        shift_en,
    output logic                        shift_up,
    output logic                        wr_en,
    output logic [WORD_W-1:0]           wr_word,
    output logic                        rd_valid,
    output logic [WORD_W-1:0]           rd_data
);
    localparam int ADDR_W = $clog2(NUM_BITS);

    typedef struct packed {
        rt_state_e         st;
        logic [ADDR_W-1:0] offset;
        logic [ADDR_W-1:0] target;
        logic              write;
        logic [WORD_W-1:0] wdata;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  go_up;

    assign go_up = ctrl_q.target > ctrl_q.offset;

    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.rd_valid = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.target = req_addr;
                    ctrl_d.write  = req_write;
                    ctrl_d.wdata  = req_wdata;
                    ctrl_d.st     = (req_addr == ctrl_q.offset) ? ST_ACCESS : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (go_up) ctrl_d.offset = ctrl_q.offset + 1'b1;
                else       ctrl_d.offset = ctrl_q.offset - 1'b1;
                if (ctrl_d.offset == ctrl_q.target) ctrl_d.st = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!ctrl_q.write) begin
                    ctrl_d.rd_valid = 1'b1;
                    ctrl_d.rd_data  = port_word;
                end
                ctrl_d.st = ST_IDLE;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st       <= ST_IDLE;
            ctrl_q.offset   <= '0;
            ctrl_q.target   <= '0;
            ctrl_q.write    <= 1'b0;
            ctrl_q.wdata    <= '0;
            ctrl_q.rd_valid <= 1'b0;
            ctrl_q.rd_data  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready = (ctrl_q.st == ST_IDLE);
    assign shift_en  = (ctrl_q.st == ST_SHIFT);
    assign shift_up  = shift_en && go_up;
    assign wr_en     = (ctrl_q.st == ST_ACCESS) && ctrl_q.write;
    assign wr_word   = ctrl_q.wdata;
    assign rd_valid  = ctrl_q.rd_valid;
    assign rd_data   = ctrl_q.rd_data;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_NO_SHIFT_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> ctrl_q.offset != ctrl_q.target); // R3

    AST_IDLE_HOLDS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(ctrl_q.offset)); // R3

    AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_up) |=> ctrl_q.offset == $past(ctrl_q.offset) + 1'b1); // R4

    AST_STEP_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !shift_up) |=> ctrl_q.offset == $past(ctrl_q.offset) - 1'b1); // R4

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_RD_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ctrl_q.st == ST_ACCESS) && !$past(ctrl_q.write)); // R7

endmodule

// File: rtl/racetrack_mem.sv
module racetrack_mem #(
    parameter int NUM_BITS = 16,
    parameter int WORD_W   = 8,
    parameter int ADDR_W   = $clog2(NUM_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              shift_active,
    output logic              shift_left
);
    logic              shift_en, shift_up, wr_en;
    logic [WORD_W-1:0] wr_word, port_word;

    rt_ctrl #(
        .NUM_BITS (NUM_BITS),
        .WORD_W   (WORD_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .port_word (port_word),
        .shift_en  (shift_en),
        .shift_up  (shift_up),
        .wr_en     (wr_en),
        .wr_word   (wr_word),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    for (genvar t = 0; t < WORD_W; t++) begin : g_track
        rt_track #(
            .NUM_BITS (NUM_BITS)
        ) track_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .shift_up (shift_up),
            .wr_en    (wr_en),
            .wr_bit   (wr_word[t]),
            .port_bit (port_word[t])
        );
    end

    assign shift_active = shift_en;
    assign shift_left   = shift_up;

    AST_NO_WRITE_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && shift_en)); // R7

    AST_DIR_ONLY_WHEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_left |-> shift_active); // R4

endmodule

// File: tb/racetrack_mem_tb_top.sv
module racetrack_mem_tb_top;
    localparam int NB = 16;
    localparam int W  = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0;
    logic          req_ready, rd_valid, shift_active, shift_left;
    logic [W-1:0]  rd_data;

    int            checks = 0, failures = 0;
    bit            done = 1'b0;
    logic [W-1:0]  model_mem [NB];
    int            model_off = 0;
    logic [W-1:0]  exp_q [$];

    always #10 clk = ~clk;

    racetrack_mem #(.NUM_BITS(NB), .WORD_W(W)) dut_i (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
        .req_wdata, .rd_valid, .rd_data, .shift_active, .shift_left
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected rd_valid", 1, 0);
            else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R6 R8 read data", int'(rd_data), int'(e));
            end
        end
    end

    task automatic do_req(input bit wr, input int addr, input logic [W-1:0] data, input bit intrude);
        int d;
        bit up;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
        chk(rd_valid == 1'b0, "R6 strobe lasts one cycle", int'(rd_valid), 0);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_wdata = data;
        up = addr > model_off;
        d  = up ? addr - model_off : model_off - addr;
        if (!wr) exp_q.push_back(model_mem[addr]);
        @(posedge clk);
        for (int k = 0; k < d; k++) begin
            @(negedge clk);
            if (k == 0) begin
                if (intrude) begin
                    req_valid = 1'b1; req_write = 1'b1;
                    req_addr = AW'((addr + 3) % NB); req_wdata = ~data;
                end else begin
                    req_valid = 1'b0;
                end
            end
            chk(shift_active == 1'b1, "R3 shift cycle", int'(shift_active), 1);
            chk(shift_left == up, "R4 direction", int'(shift_left), int'(up));
            chk(req_ready == 1'b0, "R2 busy while shifting", int'(req_ready), 0);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(shift_active == 1'b0, "R3 R5 no shift in access cycle", int'(shift_active), 0);
        chk(req_ready == 1'b0, "R2 busy in access cycle", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after access", int'(req_ready), 1);
        chk(rd_valid == !wr, "R6 R7 strobe timing", int'(rd_valid), int'(!wr));
        if (wr) model_mem[addr] = data;
        model_off = addr;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) model_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        chk(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
        chk(shift_active == 1'b0, "R1 reset shift_active", int'(shift_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(shift_left == 1'b0, "R1 idle direction", int'(shift_left), 0);
        // R1 R5: zero-distance read of an unwritten word
        do_req(1'b0, 0, '0, 1'b0);
        // R1 R4: walk to the far end and back
        do_req(1'b0, NB - 1, '0, 1'b0);
        do_req(1'b0, 0, '0, 1'b0);
        // R7: write every address in scrambled order
        for (int i = 0; i < NB; i++) do_req(1'b1, (i * 7) % NB, W'(i * 29 + 5), 1'b0);
        // R8: read back in another order
        for (int i = 0; i < NB; i++) do_req(1'b0, (i * 11 + 3) % NB, '0, 1'b0);
        // R8: extremes
        for (int i = 0; i < 3; i++) begin
            do_req(1'b0, NB - 1, '0, 1'b0);
            do_req(1'b0, 0, '0, 1'b0);
        end
        // R5: same address twice
        do_req(1'b0, 0, '0, 1'b0);
        // R10: stray writes presented while busy
        do_req(1'b1, 12, 8'hA5, 1'b1);
        do_req(1'b0, 2, '0, 1'b1);
        do_req(1'b1, 9, 8'h3C, 1'b1);
        do_req(1'b0, 15, '0, 1'b0);
        do_req(1'b0, 5, '0, 1'b0);
        do_req(1'b0, 12, '0, 1'b0);
        do_req(1'b0, 9, '0, 1'b0);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R6 every read returned", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule